// File: doc/BRIEF.md
# FIFO Threshold Offset Programmer

This block keeps the two threshold offsets of a FIFO's partial-status flags: the distance from the empty boundary at which "almost empty" should be reported, and the distance from the full boundary at which "almost full" should be reported. A single active-low load pin does two jobs. While master reset is held, its level picks a default for both offsets and also fixes the programming method until the next master reset. One level gives a small default and word-wide (parallel) programming. The other gives a large default and bit-serial programming.

After reset, holding the load pin low turns the FIFO's normal strobes into offset accesses. In parallel mode the write strobe stores the data bus into the offsets, almost-empty first and then almost-full. In either mode the read strobe returns the offsets on a readback bus in the same order. In serial mode a low serial enable shifts one bit per write-clock edge into the offsets. A write through the method that was not chosen is locked out. A partial reset restarts any access sequence in progress but keeps the offsets and the mode. Comparing the offsets against the fill level is done elsewhere.

The readback bus is a valid-only stream. `rd_valid` pulses for one cycle per accepted read. There is no ready input, so the consumer must take each word in the cycle it is presented. Back-pressure is applied by withholding the read strobe.

Top module: `ofl_offset_loader`

## Requirements
- R1: While `mrst_n` is low, a clock edge with `ld_n` low sets both offsets to 127 (0x07F) and selects parallel programming.
- R2: While `mrst_n` is low, a clock edge with `ld_n` high sets both offsets to 1023 (0x3FF) and selects serial programming.
- R3: In serial mode, each edge with `ld_n` and `sen_n` both low writes `si` into the next offset bit. Bit positions 0 to W-1 of the almost-empty offset are filled first, then bits 0 to W-1 of the almost-full offset, LSB first. Each new bit is visible after that edge.
- R4: In parallel mode, each edge with `ld_n` low and `par_wr` high stores `din` into the offset at the step pointer. The pointer alternates almost-empty, almost-full, almost-empty, and so on.
- R5: The method not chosen at reset has no effect. `par_wr` changes nothing in serial mode, and `sen_n` changes nothing in parallel mode.
- R6: In either mode, an edge with `ld_n` low and `par_rd` high presents the offset at the step pointer on `rd_data`. `rd_valid` is high for exactly the following cycle, and the pointer advances.
- R7: While `ld_n` is high, the parallel step pointer and the serial bit counter both return to their starts. The next access after `ld_n` falls therefore targets the almost-empty offset, at bit 0 in serial mode.
- R8: While `ld_n` is high, `par_wr`, `par_rd`, `sen_n` and `si` leave both offsets unchanged and `rd_valid` stays low.
- R9: When `par_wr` and `par_rd` are both high on one edge in parallel mode, the readback carries the value held before the write. The write updates the same offset, and the pointer advances once.
- R10: While `prst_n` is low, no offset access is accepted, and the pointer, the bit counter and `rd_valid` are cleared. The offsets and the programming mode are kept.
- R11: After 2·W serial bits, the bit counter wraps, and the next bit lands at bit 0 of the almost-empty offset.
- R12: With `ld_n` low and `sen_n` high in serial mode, both offsets hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock; all state changes on its rising edge |
| mrst_n | input | 1 | Master reset, active low, sampled synchronously |
| prst_n | input | 1 | Partial reset, active low, sampled synchronously |
| ld_n | input | 1 | Load pin: default/method select during master reset, access enable afterwards |
| sen_n | input | 1 | Serial enable, active low |
| si | input | 1 | Serial data bit |
| par_wr | input | 1 | Parallel write strobe |
| par_rd | input | 1 | Parallel read strobe |
| din | input | OFS_W | Parallel offset data |
| ae_offset | output | OFS_W | Almost-empty offset |
| af_offset | output | OFS_W | Almost-full offset |
| rd_data | output | OFS_W | Readback word |
| rd_valid | output | 1 | Readback word valid for one cycle |

## Verification
A parallel write and a parallel read can fall on the same edge and contend for the one step pointer and the one offset it selects. The bench provokes this by raising both strobes for two consecutive edges with new data each time. The scoreboard expects each returned word to be the pre-write contents, and it checks separately that each offset now holds the written data, so the pointer must have moved exactly once per edge. A lockout case is mixed in as well: a parallel write offered in serial mode together with a read, where the read must still be answered.

// File: rtl/ofl_pkg.sv
package ofl_pkg;
  typedef enum logic {
    PROG_PAR = 1'b0,
    PROG_SER = 1'b1
  } prog_mode_e;

  localparam int unsigned N_OFS = 2;  // index 0 = almost-empty, 1 = almost-full
endpackage

// File: rtl/ofl_mode_latch.sv
module ofl_mode_latch
  import ofl_pkg::*;
#(
  parameter int unsigned W     = 10,
  parameter int unsigned SMALL = 127,
  parameter int unsigned LARGE = 1023
) (
  input  logic         clk,
  input  logic         mrst_n,
  input  logic         ld_n,
  output prog_mode_e   mode,
  output logic [W-1:0] def_val
);
  localparam logic [W-1:0] SMALL_V = W'(SMALL);
  localparam logic [W-1:0] LARGE_V = W'(LARGE);

  // default offered to the registers during master reset
  assign def_val = ld_n ? LARGE_V : SMALL_V;

  always_ff @(posedge clk) begin
    if (!mrst_n) mode <= ld_n ? PROG_SER : PROG_PAR;
  end

  // mode moves only under master reset
  p_mode_fixed_r10: assert property (@(posedge clk) disable iff (!mrst_n)
    mrst_n |=> $stable(mode));
endmodule

// File: rtl/ofl_bit_ctr.sv
module ofl_bit_ctr #(
  parameter int unsigned W = 10
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          ld_n,
  input  logic          shift_en,
  output logic          sel_af,
  output logic [$clog2(W)-1:0] bit_pos
);
  localparam int unsigned TOTAL = 2 * W;
  localparam int unsigned CW    = $clog2(TOTAL);
  localparam int unsigned PW    = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);
  localparam logic [CW-1:0] HALF = CW'(W);

  logic [CW-1:0] idx;

  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n || ld_n) idx <= '0;
    else if (shift_en)              idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  assign sel_af  = (idx >= HALF);
  assign bit_pos = sel_af ? PW'(idx - HALF) : PW'(idx);

  // R7: a high load pin restarts the serial sequence
  p_ctr_clear_r7: assert property (@(posedge clk) disable iff (!mrst_n)
    ld_n |=> (idx == '0));
  // R11: the counter wraps after the last bit
  p_ctr_wrap_r11: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && !ld_n && shift_en && idx == LAST) |=> (idx == '0));
endmodule

// File: rtl/ofl_step_ptr.sv
module ofl_step_ptr (
  input  logic clk,
  input  logic mrst_n,
  input  logic prst_n,
  input  logic ld_n,
  input  logic step,
  output logic ptr
);
  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n || ld_n) ptr <= 1'b0;
    else if (step)                  ptr <= ~ptr;
  end

  // R7: pointer restarts at the almost-empty offset whenever load is high
  p_ptr_clear_r7: assert property (@(posedge clk) disable iff (!mrst_n)
    ld_n |=> !ptr);
  // R4/R9: one step per qualified edge
  p_ptr_step_r9: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && !ld_n && step) |=> (ptr != $past(ptr)));
endmodule

// File: rtl/ofl_offset_regs.sv
module ofl_offset_regs
  import ofl_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic [W-1:0]  def_val,
  input  logic          ser_shift,
  input  logic          ser_sel_af,
  input  logic [$clog2(W)-1:0] ser_pos,
  input  logic          si,
  input  logic          par_wr,
  input  logic          par_sel_af,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  ae_q,
  output logic [W-1:0]  af_q
);
  logic [W-1:0] ofs [N_OFS];

  for (genvar g = 0; g < N_OFS; g++) begin : g_ofs
    localparam logic SEL = (g == 1);
    always_ff @(posedge clk) begin
      if (!mrst_n)                           ofs[g] <= def_val;
      else if (ser_shift && ser_sel_af == SEL) ofs[g][ser_pos] <= si;
      else if (par_wr && par_sel_af == SEL)    ofs[g] <= din;
    end
  end

  assign ae_q = ofs[0];
  assign af_q = ofs[1];

  // R3: a serial shift touches only the addressed offset
  p_ser_one_reg_r3: assert property (@(posedge clk) disable iff (!mrst_n)
    (ser_shift && !ser_sel_af) |=> $stable(af_q));
endmodule

// File: rtl/ofl_offset_loader.sv
module ofl_offset_loader
  import ofl_pkg::*;
#(
  parameter int unsigned OFS_W     = 10,
  parameter int unsigned DEF_SMALL = 127,
  parameter int unsigned DEF_LARGE = 1023
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             ld_n,
  input  logic             sen_n,
  input  logic             si,
  input  logic             par_wr,
  input  logic             par_rd,
  input  logic [OFS_W-1:0] din,
  output logic [OFS_W-1:0] ae_offset,
  output logic [OFS_W-1:0] af_offset,
  output logic [OFS_W-1:0] rd_data,
  output logic             rd_valid
);
  localparam int unsigned PW = $clog2(OFS_W);

  prog_mode_e        mode;
  logic [OFS_W-1:0]  def_val;
  logic              load_op, ser_shift, pwr, prd, step, ptr;
  logic              ser_sel_af;
  logic [PW-1:0]     ser_pos;

  assign load_op   = !ld_n && prst_n;
  assign ser_shift = load_op && (mode == PROG_SER) && !sen_n;
  assign pwr       = load_op && (mode == PROG_PAR) && par_wr;
  assign prd       = load_op && par_rd;
  assign step      = pwr || prd;

  ofl_mode_latch #(.W(OFS_W), .SMALL(DEF_SMALL), .LARGE(DEF_LARGE)) i_mode (
    .clk(clk), .mrst_n(mrst_n), .ld_n(ld_n), .mode(mode), .def_val(def_val)
  );

  ofl_bit_ctr #(.W(OFS_W)) i_ctr (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld_n(ld_n),
    .shift_en(ser_shift), .sel_af(ser_sel_af), .bit_pos(ser_pos)
  );

  ofl_step_ptr i_ptr (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld_n(ld_n),
    .step(step), .ptr(ptr)
  );

  ofl_offset_regs #(.W(OFS_W)) i_regs (
    .clk(clk), .mrst_n(mrst_n), .def_val(def_val),
    .ser_shift(ser_shift), .ser_sel_af(ser_sel_af), .ser_pos(ser_pos), .si(si),
    .par_wr(pwr), .par_sel_af(ptr), .din(din),
    .ae_q(ae_offset), .af_q(af_offset)
  );

  // readback: captures pre-write contents, so a same-edge write is not seen
  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= prd;
      if (prd) rd_data <= ptr ? af_offset : ae_offset;
    end
  end

  // R8: load pin high leaves the offsets alone
  p_hold_ld_high_r8: assert property (@(posedge clk) disable iff (!mrst_n)
    ld_n |=> ($stable(ae_offset) && $stable(af_offset)));
  // R5: parallel write locked out in serial mode
  p_lock_par_r5: assert property (@(posedge clk) disable iff (!mrst_n)
    (mode == PROG_SER && sen_n) |=> ($stable(ae_offset) && $stable(af_offset)));
  // R5: serial enable locked out in parallel mode
  p_lock_ser_r5: assert property (@(posedge clk) disable iff (!mrst_n)
    (mode == PROG_PAR && !par_wr) |=> ($stable(ae_offset) && $stable(af_offset)));
  // R6: each accepted read yields one valid cycle
  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && !ld_n && par_rd) |=> rd_valid);
  // R6/R8: valid only after an accepted read
  p_rd_cause_r6: assert property (@(posedge clk) disable iff (!mrst_n)
    rd_valid |-> $past(!ld_n && par_rd && prst_n));
  // R10: partial reset clears the readback stream
  p_prst_clear_r10: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> !rd_valid);
endmodule

// File: tb/test_ofl_offset_loader.sv
module test_ofl_offset_loader;
  localparam int W = 10;

  logic clk = 1'b0;
  logic mrst_n, prst_n, ld_n, sen_n, si, par_wr, par_rd;
  logic [W-1:0] din, ae_offset, af_offset, rd_data;
  logic rd_valid;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];
  int rd_seen = 0;

  always #2.5 clk = ~clk;

  ofl_offset_loader #(.OFS_W(W)) i_ofl_offset_loader (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld_n(ld_n), .sen_n(sen_n),
    .si(si), .par_wr(par_wr), .par_rd(par_rd), .din(din),
    .ae_offset(ae_offset), .af_offset(af_offset),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_ofs(input string tag, input logic [W-1:0] ae, input logic [W-1:0] af);
    chk({tag, " ae"}, ae_offset, ae);
    chk({tag, " af"}, af_offset, af);
  endtask

  task automatic idle();
    ld_n = 1'b1; sen_n = 1'b1; si = 1'b0; par_wr = 1'b0; par_rd = 1'b0;
  endtask

  task automatic tick(); @(negedge clk); endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_valid) begin
      rd_seen++;
      if (exp_q.size() == 0) chk("R6 unexpected readback", rd_data, '0);
      else chk("R6 readback", rd_data, exp_q.pop_front());
    end
  end

  task automatic master_reset(input logic ld);
    idle(); ld_n = ld; mrst_n = 1'b0; prst_n = 1'b1;
    tick(); tick();
    mrst_n = 1'b1; idle(); tick();
  endtask

  task automatic pwrite(input logic [W-1:0] d);
    ld_n = 1'b0; par_wr = 1'b1; din = d; tick(); par_wr = 1'b0;
  endtask

  task automatic pread(input logic [W-1:0] e);
    exp_q.push_back(e);
    ld_n = 1'b0; par_rd = 1'b1; tick(); par_rd = 1'b0;
  endtask

  task automatic sshift(input logic b);
    ld_n = 1'b0; sen_n = 1'b0; si = b; tick(); sen_n = 1'b1;
  endtask

  task automatic sload(input logic [W-1:0] ae, input logic [W-1:0] af);
    for (int i = 0; i < 2 * W; i++) sshift(i < W ? ae[i] : af[i - W]);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    din = '0; mrst_n = 1'b0; prst_n = 1'b1; idle();
    // R1 defaults, parallel mode
    master_reset(1'b0);
    chk_ofs("R1 default", 10'h07F, 10'h07F);
    chk("R1 rd_valid idle", {9'b0, rd_valid}, '0);

    // R4 parallel write order
    pwrite(10'h155); pwrite(10'h2AA); idle(); tick();
    chk_ofs("R4 parallel write", 10'h155, 10'h2AA);

    // R5 serial locked out in parallel mode
    for (int i = 0; i < 4; i++) sshift(1'b1);
    idle(); tick();
    chk_ofs("R5 serial ignored", 10'h155, 10'h2AA);

    // R6 readback order
    pread(10'h155); pread(10'h2AA); idle(); tick(); tick();

    // R7 pointer restart on load high
    pwrite(10'h011); idle(); tick(); pwrite(10'h022); idle(); tick();
    chk_ofs("R7 pointer restart", 10'h022, 10'h2AA);

    // R8 load high ignores strobes
    idle(); par_wr = 1'b1; par_rd = 1'b1; sen_n = 1'b0; si = 1'b1; din = 10'h3EE;
    tick(); tick(); idle();
    chk_ofs("R8 load high", 10'h022, 10'h2AA);
    chk("R8 no valid", {9'b0, rd_valid}, '0);

    // R9 same-edge write and read
    ld_n = 1'b0; par_wr = 1'b1; par_rd = 1'b1;
    din = 10'h033; exp_q.push_back(10'h022); tick();
    din = 10'h044; exp_q.push_back(10'h2AA); tick();
    idle(); tick(); tick();
    chk_ofs("R9 collision", 10'h033, 10'h044);

    // R10 partial reset keeps offsets and mode, restarts pointer
    pwrite(10'h055);
    prst_n = 1'b0; par_wr = 1'b1; par_rd = 1'b1; din = 10'h066; tick();
    chk("R10 valid cleared", {9'b0, rd_valid}, '0);
    prst_n = 1'b1; par_wr = 1'b0; par_rd = 1'b0;
    chk_ofs("R10 kept", 10'h055, 10'h044);
    pwrite(10'h077); idle(); tick();
    chk_ofs("R10 pointer restart", 10'h077, 10'h044);
    sshift(1'b1); sshift(1'b0); idle(); tick();
    chk_ofs("R10 mode kept", 10'h077, 10'h044);

    // R2 defaults, serial mode
    master_reset(1'b1);
    chk_ofs("R2 default", 10'h3FF, 10'h3FF);

    // R3 serial load order
    sload(10'h0A5, 10'h35A); idle(); tick();
    chk_ofs("R3 serial load", 10'h0A5, 10'h35A);

    // R5 parallel write locked out, readback still works (R6)
    ld_n = 1'b0; par_wr = 1'b1; par_rd = 1'b1; din = 10'h111;
    exp_q.push_back(10'h0A5); tick();
    exp_q.push_back(10'h35A); tick();
    idle(); tick(); tick();
    chk_ofs("R5 parallel ignored", 10'h0A5, 10'h35A);

    // R12 serial enable high holds
    ld_n = 1'b0; sen_n = 1'b1; si = 1'b1; tick(); si = 1'b0; tick(); si = 1'b1; tick();
    idle(); tick();
    chk_ofs("R12 sen high", 10'h0A5, 10'h35A);

    // R8 in serial mode
    idle(); sen_n = 1'b0; si = 1'b1; tick(); tick(); idle();
    chk_ofs("R8 serial load high", 10'h0A5, 10'h35A);

    // R11 wrap after 2W bits
    sload(10'h3C3, 10'h0F0);
    sshift(1'b1); sshift(1'b1); sshift(1'b1);
    chk_ofs("R11 wrap", 10'h3C7, 10'h0F0);

    // R7 serial counter restart
    idle(); tick();
    sshift(1'b0); sshift(1'b0); idle(); tick();
    chk_ofs("R7 counter restart", 10'h3C4, 10'h0F0);

    tick();
    chk("R6 reads answered", W'(exp_q.size()), '0);
    chk("R6 read count", W'(rd_seen), W'(6));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule